// File: doc/BRIEF.md
# Timer Event Status Flags

This block holds the sticky event flags for a 16-bit up/down timer that has four general registers, A to D, each configured as either output-compare or input-capture. For each timer channel it records counter overflow, counter underflow (second channel only) and a compare-match or capture event on each of the four general registers. Each flag raises that channel's interrupt request as a level while the matching interrupt-enable bit is 1.

Software reads a channel's flags over a simple byte-wide bus. A flag can only be cleared by a two-step sequence. First, a read strobe must observe the flag at 1, which arms that bit. Then a later write must put 0 in that bit position. Any completed write cancels all arming on that channel. The read data always shows the selected channel's current flags. Only an asserted read strobe arms bits.

If a read and a write to the same channel fall in the same cycle, the write is handled and all arming on that channel is cleared.

Top module: `tmr_flag_reg`

## Requirements
- R1: Read data bits 7 and 6 are always 1, and writes to them have no effect.
- R2: A pulse on a channel's overflow event sets flag bit 4 of that channel on the next clock edge.
- R3: On channel 1, an underflow event sets flag bit 5. On channel 0, bit 5 always reads 0 and the underflow event is ignored.
- R4: A general register in compare mode (capture-select bit = 0) sets its flag on a match pulse. Bit positions are A=0, B=1, C=2 and D=3. A capture-edge pulse is ignored in this mode.
- R5: A general register in capture mode (capture-select bit = 1) sets its flag on a capture-edge pulse. A match pulse is ignored in this mode.
- R6: A write with 0 in a bit position clears that flag if an earlier read strobe on that channel saw the flag at 1.
- R7: Writing 0 to a flag that was not armed leaves it set. Writing 1 to any flag never changes it.
- R8: Any completed write to a channel cancels all arming on it, so a second zero-write without a new read does not clear.
- R9: When a set event and a valid clearing write hit the same flag in the same cycle, the flag stays 1.
- R10: irq[c] is 1 exactly when some flag of channel c is 1 and its enable bit irq_en[c*8+bit] is 1. Enable bit positions match the flag positions.
- R11: Bus accesses and events on one channel do not change the other channel's flags.
- R12: After reset, all flags and all arming are 0, read data is 0xC0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Channel select for read data and accesses |
| bus_rd | input | 1 | Read strobe; arms flags seen at 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; 0 in a bit requests a clear |
| bus_rdata | output | 8 | Selected channel's status byte |
| ovf_evt | input | 2 | Per-channel counter overflow pulse |
| udf_evt | input | 2 | Per-channel counter underflow pulse |
| gr_capture | input | 8 | Per channel, per general register: 1 = capture mode |
| gr_match | input | 8 | Per channel, per general register: counter equals register |
| gr_cap_edge | input | 8 | Per channel, per general register: capture edge occurred |
| irq_en | input | 16 | Per-channel interrupt-enable byte |
| irq | output | 2 | Per-channel interrupt request level |

## Verification
A flag can be set by an event and cleared by an armed zero-write in the same cycle. The bench first arms a channel with a read. In the following cycle it drives the zero-write together with an overflow pulse. It then checks that the overflow flag survives while the other armed flags clear. A second collision, a read and a write in the same cycle, is resolved in favour of the write. It is judged through the cancelled-arming check: a later zero-write must fail to clear.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int NUM_GR  = 4;
    localparam int FLAG_W  = NUM_GR + 2;
    localparam int BYTE_W  = 8;
    localparam int OVF_BIT = NUM_GR;
    localparam int UDF_BIT = NUM_GR + 1;

    typedef struct packed {
        logic [FLAG_W-1:0] flag;
        logic [FLAG_W-1:0] arm;
    } chan_st_t;
endpackage

// File: rtl/tsf_event_decode.sv
module tsf_event_decode
    import tsf_pkg::*;
(
    input  logic [NUM_GR-1:0] mode_cap,
    input  logic [NUM_GR-1:0] match,
    input  logic [NUM_GR-1:0] cap_edge,
    output logic [NUM_GR-1:0] hit
);
    for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
        assign hit[g] = mode_cap[g] ? cap_edge[g] : match[g];
    end
endmodule

// File: rtl/tsf_channel.sv
module tsf_channel
    import tsf_pkg::*;
#(
    parameter bit HAS_UDF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [FLAG_W-1:0] wdata,
    input  logic [FLAG_W-1:0] set_vec,
    output logic [FLAG_W-1:0] flags
);
    localparam logic [FLAG_W-1:0] KEEP_MASK =
        HAS_UDF ? {FLAG_W{1'b1}} : ~(FLAG_W'(1) << UDF_BIT);

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.flag = st_q.flag & ~(st_q.arm & ~wdata);
            st_d.arm  = '0;
        end else if (rd) begin
            st_d.arm = st_q.arm | st_q.flag;
        end
        st_d.flag = (st_d.flag | set_vec) & KEEP_MASK;
        st_d.arm  = st_d.arm & KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flag;
endmodule

// File: rtl/tsf_irq_reduce.sv
module tsf_irq_reduce
    import tsf_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] en,
    output logic              irq
);
    assign irq = |(flags & en);
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg
    import tsf_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         bus_sel,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]        ovf_evt,
    input  logic [NUM_CH-1:0]        udf_evt,
    input  logic [NUM_CH*NUM_GR-1:0] gr_capture,
    input  logic [NUM_CH*NUM_GR-1:0] gr_match,
    input  logic [NUM_CH*NUM_GR-1:0] gr_cap_edge,
    input  logic [NUM_CH*BYTE_W-1:0] irq_en,
    output logic [NUM_CH-1:0]        irq
);
    localparam int RSV_W = BYTE_W - FLAG_W;

    logic [NUM_CH*FLAG_W-1:0] flags_all;
    logic [NUM_CH*RSV_W-1:0]  unused_en_bits;
    logic                     unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata[BYTE_W-1:FLAG_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic              sel_c;
        logic [NUM_GR-1:0] gr_hit;
        logic [FLAG_W-1:0] set_vec;

        assign sel_c = (bus_sel == SEL_W'(c));

        tsf_event_decode u_dec (
            .mode_cap (gr_capture[c*NUM_GR +: NUM_GR]),
            .match    (gr_match[c*NUM_GR +: NUM_GR]),
            .cap_edge (gr_cap_edge[c*NUM_GR +: NUM_GR]),
            .hit      (gr_hit)
        );

        assign set_vec = {udf_evt[c], ovf_evt[c], gr_hit};

        tsf_channel #(.HAS_UDF(c == 1)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd      (bus_rd & sel_c),
            .wr      (bus_wr & sel_c),
            .wdata   (bus_wdata[FLAG_W-1:0]),
            .set_vec (set_vec),
            .flags   (flags_all[c*FLAG_W +: FLAG_W])
        );

        tsf_irq_reduce u_irq (
            .flags (flags_all[c*FLAG_W +: FLAG_W]),
            .en    (irq_en[c*BYTE_W +: FLAG_W]),
            .irq   (irq[c])
        );

        assign unused_en_bits[c*RSV_W +: RSV_W] = irq_en[c*BYTE_W+FLAG_W +: RSV_W];
    end

    always_comb begin
        bus_rdata = {{RSV_W{1'b1}}, {FLAG_W{1'b0}}};
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_sel == SEL_W'(c))
                bus_rdata = {{RSV_W{1'b1}}, flags_all[c*FLAG_W +: FLAG_W]};
        end
    end
endmodule

// File: rtl/tmr_flag_reg_chk.sv
module tmr_flag_reg_chk
    import tsf_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [SEL_W-1:0]         bus_sel,
    input logic                     bus_wr,
    input logic [BYTE_W-1:0]        bus_rdata,
    input logic [NUM_CH-1:0]        ovf_evt,
    input logic [NUM_CH-1:0]        udf_evt,
    input logic [NUM_CH*BYTE_W-1:0] irq_en,
    input logic [NUM_CH-1:0]        irq,
    input logic [NUM_CH*FLAG_W-1:0] flags_all
);
    p_reserved_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BYTE_W-1:FLAG_W] == '1);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_ovf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_evt[c] |=> flags_all[c*FLAG_W + OVF_BIT]);

        if (c == 1) begin : g_udf
            p_udf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
                udf_evt[c] |=> flags_all[c*FLAG_W + UDF_BIT]);
        end else begin : g_noudf
            p_udf_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !flags_all[c*FLAG_W + UDF_BIT]);
        end

        p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] == |(flags_all[c*FLAG_W +: FLAG_W] & irq_en[c*BYTE_W +: FLAG_W]));

        for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
            p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_all[c*FLAG_W + b] && !(bus_wr && bus_sel == SEL_W'(c)))
                |=> flags_all[c*FLAG_W + b]);
        end
    end
endmodule

bind tmr_flag_reg tmr_flag_reg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .ovf_evt   (ovf_evt),
    .udf_evt   (udf_evt),
    .irq_en    (irq_en),
    .irq       (irq),
    .flags_all (flags_all)
);

// File: tb/test_tmr_flag_reg.sv
module test_tmr_flag_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] bus_sel = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ovf_evt = '0, udf_evt = '0;
    logic [7:0] gr_capture = '0, gr_match = '0, gr_cap_edge = '0;
    logic [15:0] irq_en = '0;
    logic [1:0] irq;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    tmr_flag_reg i_tmr_flag_reg (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_evt(ovf_evt), .udf_evt(udf_evt),
        .gr_capture(gr_capture), .gr_match(gr_match), .gr_cap_edge(gr_cap_edge),
        .irq_en(irq_en), .irq(irq)
    );

    typedef struct packed {
        logic       ch;
        logic [1:0] op;   // 0 overflow, 1 read, 2 write, 3 match pulse
        logic [7:0] val;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b0, 2'd3, 8'h01, 8'hC1},  // R4 compare match A
        '{1'b0, 2'd2, 8'h00, 8'hC1},  // R7 zero-write unarmed
        '{1'b0, 2'd1, 8'h00, 8'hC1},  // arm
        '{1'b0, 2'd2, 8'hFE, 8'hC0},  // R6 armed clear
        '{1'b0, 2'd0, 8'h00, 8'hD0},  // R2 overflow
        '{1'b0, 2'd1, 8'h00, 8'hD0},  // arm
        '{1'b0, 2'd2, 8'hFF, 8'hD0},  // R7 ones do not clear
        '{1'b0, 2'd2, 8'hEF, 8'hD0},  // R8 arming cancelled
        '{1'b1, 2'd0, 8'h00, 8'hD0},  // R2 overflow ch1
        '{1'b0, 2'd2, 8'h00, 8'hD0}   // R11 ch0 untouched
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        ovf_evt = '0; udf_evt = '0; gr_match = '0; gr_cap_edge = '0;
    endtask

    task automatic peek(input logic ch, input string req, input logic [7:0] exp);
        bus_sel = ch;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic rd_wr(input logic ch, input logic [7:0] val);
        @(negedge clk); bus_sel = ch; bus_rd = 1'b1;
        idle();
        bus_sel = ch; bus_wr = 1'b1; bus_wdata = val;
        idle();
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(1'b0, "R12 ch0 reset", 8'hC0);
        peek(1'b1, "R12 ch1 reset", 8'hC0);
        check("R12 irq reset", {6'd0, irq}, 8'h00);

        foreach (VEC[i]) begin
            @(negedge clk);
            bus_sel = VEC[i].ch;
            case (VEC[i].op)
                2'd0: ovf_evt[VEC[i].ch] = 1'b1;
                2'd1: bus_rd = 1'b1;
                2'd2: begin bus_wr = 1'b1; bus_wdata = VEC[i].val; end
                default: gr_match[VEC[i].ch*4 +: 4] = VEC[i].val[3:0];
            endcase
            if (VEC[i].op == 2'd1) #1 check($sformatf("R1 read vec %0d", i), bus_rdata, VEC[i].exp);
            idle();
            peek(VEC[i].ch, $sformatf("R6 R7 R8 vec %0d", i), VEC[i].exp);
        end
        peek(1'b1, "R11 ch1 untouched", 8'hD0);

        // R5: ch1 register C in capture mode
        gr_capture[6] = 1'b1;
        @(negedge clk); gr_match[6] = 1'b1; idle();
        peek(1'b1, "R5 match ignored in capture", 8'hD0);
        @(negedge clk); gr_cap_edge[6] = 1'b1; idle();
        peek(1'b1, "R5 capture edge sets C", 8'hD4);
        // R4: ch0 register D compare mode ignores capture edge
        @(negedge clk); gr_cap_edge[3] = 1'b1; idle();
        peek(1'b0, "R4 edge ignored in compare", 8'hD0);

        // R3 underflow
        @(negedge clk); udf_evt = 2'b11; idle();
        peek(1'b1, "R3 ch1 underflow", 8'hF4);
        peek(1'b0, "R3 ch0 no underflow", 8'hD0);

        // R9: armed zero-write collides with overflow
        @(negedge clk); bus_sel = 1'b1; bus_rd = 1'b1;
        idle();
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00; ovf_evt[1] = 1'b1;
        idle();
        peek(1'b1, "R9 set wins", 8'hD0);

        // R8: read and write in the same cycle, write wins, arming cancelled
        @(negedge clk); bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'hFF;
        idle();
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
        idle();
        peek(1'b1, "R8 same-cycle read not armed", 8'hD0);

        // R10 interrupts
        irq_en = 16'h1000;
        #1 check("R10 irq ch1 enabled", {6'd0, irq}, 8'h02);
        irq_en = 16'h1001;
        #1 check("R10 irq ch0 bit0 clear", {6'd0, irq}, 8'h02);
        irq_en = 16'h1011;
        #1 check("R10 irq both", {6'd0, irq}, 8'h03);
        rd_wr(1'b1, 8'h00);
        peek(1'b1, "R6 ch1 cleared", 8'hC0);
        check("R10 irq ch1 drops", {6'd0, irq}, 8'h01);
        rd_wr(1'b0, 8'h3F);
        peek(1'b0, "R1 reserved unaffected", 8'hD0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule